// File: doc/BRIEF.md
# SD Card Command Path Engine

This block sends one command frame to an SD or MMC card on the bidirectional CMD line and, when asked to, collects the card's reply. A single write strobe loads a 32-bit argument together with a command word. The command word holds the 6-bit command index, a 2-bit field that sets both the reply length and whether the reply CRC is checked, a run bit, a data-transfer marker and a stop-transmission marker. The engine first holds CMD high for a preamble. It then shifts out the 48-bit frame, MSB first, with a CRC7 it computes itself. After the frame it releases the line and waits a fixed number of card clocks for a start bit.

A reply is shifted in and placed in four 32-bit response words. The engine then reports the outcome on exactly one of four single-cycle outcome pulses. Two further pulses feed the data path: one starts a data transfer when a command that carries the transfer marker completes successfully, and one orders the data path to abort as soon as a stop command has left the wire. One card clock equals one cycle of `clk`. The design has an output-enable for the external CMD pad.

Top module: `sd_cmd_path`

## Requirements
- R1: The transmitted frame is, MSB first: a 0 start bit, a 1 direction bit, command index bits 5:0 of the command word, the 32-bit argument, a CRC7 and a 1 end bit. The CRC7 uses generator x^7 + x^3 + 1 over the first 40 bits. For index 0 with argument 0 the last byte on the wire is 0x95, and for index 8 with argument 0x1AA it is 0x87.
- R2: After reset, and whenever no frame is being sent, `cmd_oe` is low and the response words read zero until the first reply. Every frame is preceded by exactly GAP_CYC (default 8) cycles with `cmd_oe` high and `cmd_out` high.
- R3: Command word bits 9:8 select the reply: 00 none, 01 short 48-bit reply with CRC check, 10 short reply without CRC check, 11 long 136-bit reply with CRC check. A good reply raises `rsp_done`.
- R4: With reply type 00, the only outcome pulse is `sent`, raised in the cycle after the end bit.
- R5: A reply start bit (CMD low) must be sampled within RSP_TIMEOUT (default 64) cycles after the end bit. Otherwise `rsp_timeout` is raised, and a start bit that arrives later is ignored.
- R6: A short reply loads its 32 content bits into `rsp0` and its index field into `rsp_idx`, and clears `rsp1` to `rsp3`.
- R7: A long reply is checked with CRC7 over its 120 content bits that follow the 8 header bits. Its 128 bits after the header (content, CRC, end bit) load `rsp0` (bits 127:96) through `rsp3` (bits 31:0), and `rsp_idx` reads 0x3F.
- R8: On a CRC mismatch, `rsp_crc_err` is raised instead of `rsp_done` for types 01 and 11. Type 10 ignores the mismatch and raises `rsp_done`.
- R9: A write with command word bit 12 set starts a command. A write with bit 12 clear aborts any command in progress: in the next cycle `busy` and `cmd_oe` are low, and no outcome pulse follows. In idle such a write has no effect. Bits 11:10 are reserved and written as zero.
- R10: Command word bit 6 makes `xfer_go` pulse together with `sent` or `rsp_done`. Bit 7 makes `abort_go` pulse in the cycle after the stop frame's end bit.
- R11: Outcome pulses last one cycle, at most one is high at a time, and `busy` is low whenever one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Load strobe for word and argument |
| cmd_word | input | 13 | Index, markers, reply type, run bit |
| cmd_arg | input | 32 | Command argument |
| cmd_in | input | 1 | CMD line as seen from the pad |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD pad output enable |
| busy | output | 1 | A command is in progress |
| sent | output | 1 | No-reply command finished |
| rsp_done | output | 1 | Reply received and accepted |
| rsp_timeout | output | 1 | No reply start in time |
| rsp_crc_err | output | 1 | Reply CRC mismatch |
| xfer_go | output | 1 | Start the data transfer |
| abort_go | output | 1 | Abort the data transfer |
| rsp_idx | output | 6 | Index field of the last reply |
| rsp0 | output | 32 | Response word 0 |
| rsp1 | output | 32 | Response word 1 |
| rsp2 | output | 32 | Response word 2 |
| rsp3 | output | 32 | Response word 3 |

## Verification
A wrong bit counter shows up at once on the wire: the preamble length or the frame contents differ, and the fault is visible within the first 56 cycles of a command. A wrong CRC register or a wrong coverage window appears as a wrong last byte on transmit. On receive it raises the wrong outcome pulse a cycle after the reply's end bit. A broken wait counter moves the boundary between an accepted reply and a timeout. The bench sweeps every reply type over several indices, delays and marker combinations, and probes the delays right at that boundary.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int WORD_W    = 13;
  localparam int ARG_W     = 32;
  localparam int IDX_W     = 6;
  localparam int CRC_W     = 7;
  localparam int RESP_W    = 128;
  localparam int RUN_BIT   = 12;
  localparam int XFER_BIT  = 6;
  localparam int STOP_BIT  = 7;
  localparam int RT_LSB    = 8;
  localparam int HEAD_W    = 2 + IDX_W + ARG_W;        // bits covered by CRC
  localparam int FRAME_W   = HEAD_W + CRC_W + 1;       // 48
  localparam int LONG_W    = 8 + RESP_W;               // 136
  localparam int LONG_HDR  = 7;                        // header bits after start
  localparam int LONG_BODY = RESP_W - CRC_W - 1;       // 120

  typedef enum logic [1:0] {
    RT_NONE      = 2'b00,
    RT_SHORT_CRC = 2'b01,
    RT_SHORT_RAW = 2'b10,
    RT_LONG      = 2'b11
  } rtype_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_TX, ST_WAIT, ST_RX, ST_DONE
  } state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb    = din ^ crc[W-1];
    crc_d = crc;
    if (clr)        crc_d = '0;
    else if (upd)   crc_d = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shift) crc_d = {crc[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else        crc <= crc_d;
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx import sdcmd_pkg::*; #(
  parameter int IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HEAD_W-1:0] head,
  input  logic              adv,
  input  logic [IW-1:0]     bit_idx,
  output logic              txd
);
  logic [HEAD_W-1:0] sh_q, sh_d;
  logic [CRC_W-1:0]  crc;
  logic              in_head, in_crc;

  always_comb begin
    in_head = bit_idx < IW'(HEAD_W);
    in_crc  = !in_head && (bit_idx < IW'(FRAME_W - 1));
    sh_d    = sh_q;
    if (load)              sh_d = head;
    else if (adv && in_head) sh_d = {sh_q[HEAD_W-2:0], 1'b0};
    txd = in_head ? sh_q[HEAD_W-1] : (in_crc ? crc[CRC_W-1] : 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  sdcmd_crc7 #(.W(CRC_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .upd   (adv && in_head),
    .shift (adv && in_crc),
    .din   (sh_q[HEAD_W-1]),
    .crc   (crc)
  );
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx import sdcmd_pkg::*; #(
  parameter int IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              rxd,
  input  logic              long_mode,
  input  logic [IW-1:0]     bit_idx,
  output logic [RESP_W-1:0] sh_q,
  output logic              crc_ok
);
  localparam int SHORT_COVER = HEAD_W - 1;   // bits after the start bit
  logic [RESP_W-1:0] sh_d;
  logic [CRC_W-1:0]  crc;
  logic              covered;

  always_comb begin
    if (long_mode)
      covered = (bit_idx >= IW'(LONG_HDR)) && (bit_idx < IW'(LONG_HDR + LONG_BODY));
    else
      covered = bit_idx < IW'(SHORT_COVER);
    sh_d   = adv ? {sh_q[RESP_W-2:0], rxd} : sh_q;
    crc_ok = (crc == sh_q[CRC_W:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  sdcmd_crc7 #(.W(CRC_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .upd   (adv && covered),
    .shift (1'b0),
    .din   (rxd),
    .crc   (crc)
  );
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path import sdcmd_pkg::*; #(
  parameter int GAP_CYC     = 8,
  parameter int RSP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              sent,
  output logic              rsp_done,
  output logic              rsp_timeout,
  output logic              rsp_crc_err,
  output logic              xfer_go,
  output logic              abort_go,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [31:0]       rsp0,
  output logic [31:0]       rsp1,
  output logic [31:0]       rsp2,
  output logic [31:0]       rsp3
);
  localparam int CNT_A      = (RSP_TIMEOUT > LONG_W) ? RSP_TIMEOUT : LONG_W;
  localparam int CNT_MAX    = (GAP_CYC > CNT_A) ? GAP_CYC : CNT_A;
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam int TX_LAST    = FRAME_W - 1;
  localparam int SHORT_LAST = FRAME_W - 2;
  localparam int LONG_LAST  = LONG_W - 2;

  state_e            state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  rtype_e            rt_q;
  logic              xfer_q, stop_q;
  logic              sent_d, done_d, to_d, crc_d, xgo_d, ago_d;
  logic              tx_load, tx_adv, rx_clr, rx_adv, resp_ld, txd, crc_ok;
  logic [RESP_W-1:0] rx_sh, resp_q, resp_n;
  logic [IDX_W-1:0]  idx_n;
  logic              is_long;

  assign is_long = (rt_q == RT_LONG);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sent_d  = 1'b0; done_d = 1'b0; to_d = 1'b0; crc_d = 1'b0;
    xgo_d   = 1'b0; ago_d  = 1'b0;
    tx_load = 1'b0; tx_adv = 1'b0; rx_clr = 1'b0; rx_adv = 1'b0;
    resp_ld = 1'b0;
    if (cmd_wr) begin
      cnt_d = '0;
      if (cmd_word[RUN_BIT]) begin
        state_d = ST_GAP;
        tx_load = 1'b1;
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      case (state_q)
        ST_GAP: begin
          if (cnt_q == CW'(GAP_CYC - 1)) begin
            state_d = ST_TX;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_TX: begin
          tx_adv = 1'b1;
          if (cnt_q == CW'(TX_LAST)) begin
            ago_d = stop_q;
            cnt_d = '0;
            if (rt_q == RT_NONE) begin
              state_d = ST_IDLE;
              sent_d  = 1'b1;
              xgo_d   = xfer_q;
            end else state_d = ST_WAIT;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_WAIT: begin
          if (!cmd_in) begin
            state_d = ST_RX;
            cnt_d   = '0;
            rx_clr  = 1'b1;
          end else if (cnt_q == CW'(RSP_TIMEOUT - 1)) begin
            state_d = ST_IDLE;
            to_d    = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_RX: begin
          rx_adv = 1'b1;
          if (cnt_q == (is_long ? CW'(LONG_LAST) : CW'(SHORT_LAST))) state_d = ST_DONE;
          else cnt_d = cnt_q + 1'b1;
        end
        ST_DONE: begin
          resp_ld = 1'b1;
          state_d = ST_IDLE;
          if ((rt_q != RT_SHORT_RAW) && !crc_ok) crc_d = 1'b1;
          else begin
            done_d = 1'b1;
            xgo_d  = xfer_q;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // response word assembly
  always_comb begin
    if (is_long) begin
      resp_n = rx_sh;
      idx_n  = '1;
    end else begin
      resp_n = {rx_sh[ARG_W+CRC_W:CRC_W+1], {(RESP_W-ARG_W){1'b0}}};
      idx_n  = rx_sh[ARG_W+CRC_W+IDX_W:ARG_W+CRC_W+1];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rt_q        <= RT_NONE;
      xfer_q      <= 1'b0;
      stop_q      <= 1'b0;
      sent        <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_crc_err <= 1'b0;
      xfer_go     <= 1'b0;
      abort_go    <= 1'b0;
      resp_q      <= '0;
      rsp_idx     <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      sent        <= sent_d;
      rsp_done    <= done_d;
      rsp_timeout <= to_d;
      rsp_crc_err <= crc_d;
      xfer_go     <= xgo_d;
      abort_go    <= ago_d;
      if (tx_load) begin
        rt_q   <= rtype_e'(cmd_word[RT_LSB+1:RT_LSB]);
        xfer_q <= cmd_word[XFER_BIT];
        stop_q <= cmd_word[STOP_BIT];
      end
      if (resp_ld) begin
        resp_q  <= resp_n;
        rsp_idx <= idx_n;
      end
    end
  end

  assign rsp0    = resp_q[127:96];
  assign rsp1    = resp_q[95:64];
  assign rsp2    = resp_q[63:32];
  assign rsp3    = resp_q[31:0];
  assign busy    = (state_q != ST_IDLE);
  assign cmd_oe  = (state_q == ST_GAP) || (state_q == ST_TX);
  assign cmd_out = (state_q == ST_TX) ? txd : 1'b1;

  sdcmd_tx #(.IW(CW)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tx_load),
    .head    ({2'b01, cmd_word[IDX_W-1:0], cmd_arg}),
    .adv     (tx_adv),
    .bit_idx (cnt_q),
    .txd     (txd)
  );

  sdcmd_rx #(.IW(CW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .adv       (rx_adv),
    .rxd       (cmd_in),
    .long_mode (is_long),
    .bit_idx   (cnt_q),
    .sh_q      (rx_sh),
    .crc_ok    (crc_ok)
  );

  AST_SENT_ONLY_NORESP: assert property (@(posedge clk) disable iff (!rst_n)
    sent |-> (rt_q == RT_NONE)); // R4
  AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sent, rsp_done, rsp_timeout, rsp_crc_err})); // R11
  AST_IDLE_ON_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (sent || rsp_done || rsp_timeout || rsp_crc_err) |-> !busy); // R11
  AST_RAW_NEVER_CRCERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_crc_err |-> (rt_q != RT_SHORT_RAW)); // R8
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_word[RUN_BIT]) |=> (!busy && !cmd_oe)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_word[11:10] == 2'b00)); // R9
  AST_TIMEOUT_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> $past(cmd_in)); // R5
  AST_XFER_WITH_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (sent || rsp_done)); // R10
endmodule

// File: tb/sd_cmd_path_bench.sv
module sd_cmd_path_bench;
  localparam int TO  = 64;
  localparam int GAP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [12:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy, sent, rsp_done, rsp_timeout, rsp_crc_err;
  logic        xfer_go, abort_go;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;

  int n_chk = 0, n_fail = 0;
  int c_sent = 0, c_done = 0, c_to = 0, c_crc = 0, c_xgo = 0, c_ago = 0;

  always #5 clk = ~clk;

  sd_cmd_path #(.GAP_CYC(GAP), .RSP_TIMEOUT(TO)) u_sd_cmd_path (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cmd_arg(cmd_arg), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .busy(busy), .sent(sent), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
    .rsp_crc_err(rsp_crc_err), .xfer_go(xfer_go), .abort_go(abort_go),
    .rsp_idx(rsp_idx), .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sent)        c_sent++;
      if (rsp_done)    c_done++;
      if (rsp_timeout) c_to++;
      if (rsp_crc_err) c_crc++;
      if (xfer_go)     c_xgo++;
      if (abort_go)    c_ago++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7f(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic issue(input logic [12:0] w, input logic [31:0] a);
    @(negedge clk);
    cmd_word = w; cmd_arg = a; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic grab(output int gap, output logic [47:0] fr);
    gap = 0; fr = '0;
    while (!cmd_oe) @(negedge clk);
    while (cmd_out && cmd_oe) begin gap++; @(negedge clk); end
    for (int i = 47; i >= 0; i--) begin
      fr[i] = cmd_out;
      if (i > 0) @(negedge clk);
    end
  endtask

  task automatic respond(input logic [135:0] bits, input int n, input int dly);
    @(negedge clk);
    repeat (dly) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_in = bits[i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic do_cmd(input logic [5:0] op, input logic [31:0] arg,
                        input logic [1:0] rt, input bit dat, input bit stp,
                        input int dly, input bit bad, input logic [127:0] lpay,
                        output logic [47:0] fr);
    int s_sent = c_sent, s_done = c_done, s_to = c_to, s_crc = c_crc;
    int s_xgo = c_xgo, s_ago = c_ago;
    logic [12:0]  w = '0;
    logic [39:0]  head = {2'b01, op, arg};
    logic [47:0]  exp_fr = {head, crc7f({96'b0, head}, 40), 1'b1};
    logic [31:0]  rarg = arg ^ 32'h5A5A_0F0F;
    logic [39:0]  rhead = {2'b00, op, rarg};
    logic [119:0] body = lpay[127:8];
    logic [6:0]   rc;
    logic [135:0] rbits;
    logic [127:0] exp_resp;
    logic [5:0]   exp_idx;
    int           gap, nbits;
    bit           ok_rsp, succ;
    logic [3:0]   exp_out, got_out;
    string        tag;
    w[12] = 1'b1; w[9:8] = rt; w[7] = stp; w[6] = dat; w[5:0] = op;
    issue(w, arg);
    grab(gap, fr);
    chk(gap == GAP, "R2 preamble length", 128'(gap), 128'(GAP));
    chk(fr == exp_fr, "R1 frame bits", 128'(fr), 128'(exp_fr));
    if (rt == 2'b11) begin
      rc = crc7f({16'b0, body}, 120) ^ (bad ? 7'h04 : 7'h00);
      rbits = {2'b00, 6'h3F, body, rc, 1'b1};
      nbits = 136;
      exp_resp = {body, rc, 1'b1};
      exp_idx = 6'h3F;
    end else begin
      rc = crc7f({96'b0, rhead}, 40) ^ (bad ? 7'h01 : 7'h00);
      rbits = {88'b0, rhead, rc, 1'b1};
      nbits = 48;
      exp_resp = {rarg, 96'b0};
      exp_idx = op;
    end
    if (rt != 2'b00) respond(rbits, nbits, dly);
    repeat (3) @(negedge clk);
    ok_rsp = (dly < TO) && !(bad && rt != 2'b10);
    succ = (rt == 2'b00) || ok_rsp;
    if (rt == 2'b00)    begin exp_out = 4'b1000; tag = "R4 outcome no reply"; end
    else if (dly >= TO) begin exp_out = 4'b0010; tag = "R5 outcome timeout"; end
    else if (ok_rsp)    begin exp_out = 4'b0100; tag = bad ? "R8 raw type ignores crc" : "R3 outcome reply ok"; end
    else                begin exp_out = 4'b0001; tag = "R8 outcome crc fail"; end
    got_out = {4'(c_sent - s_sent), 4'(c_done - s_done), 4'(c_to - s_to), 4'(c_crc - s_crc)};
    chk(((c_sent - s_sent) == int'(exp_out[3])) && ((c_done - s_done) == int'(exp_out[2])) &&
        ((c_to - s_to) == int'(exp_out[1])) && ((c_crc - s_crc) == int'(exp_out[0])),
        tag, 128'(got_out), 128'(exp_out));
    if (rt != 2'b00 && dly < TO) begin
      chk({rsp0, rsp1, rsp2, rsp3} == exp_resp, (rt == 2'b11) ? "R7 long words" : "R6 short words",
          {rsp0, rsp1, rsp2, rsp3}, exp_resp);
      chk(rsp_idx == exp_idx, (rt == 2'b11) ? "R7 index" : "R6 index", 128'(rsp_idx), 128'(exp_idx));
    end
    chk((c_xgo - s_xgo) == int'(dat && succ), "R10 xfer_go count", 128'(c_xgo - s_xgo), 128'(dat && succ));
    chk((c_ago - s_ago) == int'(stp), "R10 abort_go count", 128'(c_ago - s_ago), 128'(stp));
    chk(!busy && !cmd_oe, "R11 idle after outcome", {busy, cmd_oe}, 128'(0));
  endtask

  task automatic abort_at(input int k, input logic [1:0] rt);
    int s_all = c_sent + c_done + c_to + c_crc;
    logic [12:0] w = '0;
    bit seen_oe = 1'b0;
    w[12] = 1'b1; w[9:8] = rt; w[5:0] = 6'd17;
    issue(w, 32'hDEAD_BEEF);
    repeat (k) @(negedge clk);
    issue(13'h0011, 32'h0);
    chk(!busy && !cmd_oe, "R9 abort releases line", {busy, cmd_oe}, 128'(0));
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (cmd_oe) seen_oe = 1'b1;
    end
    chk(!seen_oe && (c_sent + c_done + c_to + c_crc) == s_all, "R9 no outcome after abort",
        {seen_oe, 32'(c_sent + c_done + c_to + c_crc - s_all)}, 128'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] fr;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_oe && !busy, "R2 reset line released", {cmd_oe, busy}, 128'(0));
    chk({rsp0, rsp1, rsp2, rsp3} == '0, "R2 reset response zero", {rsp0, rsp1, rsp2, rsp3}, 128'(0));
    chk({sent, rsp_done, rsp_timeout, rsp_crc_err, xfer_go, abort_go} == '0,
        "R11 reset outcomes low", 128'({sent, rsp_done, rsp_timeout, rsp_crc_err}), 128'(0));

    // known CRC vectors
    do_cmd(6'd0, 32'h0, 2'b00, 1'b0, 1'b0, 0, 1'b0, '0, fr);
    chk(fr[7:0] == 8'h95, "R1 index0 last byte", 128'(fr[7:0]), 128'h95);
    do_cmd(6'd8, 32'h1AA, 2'b01, 1'b0, 1'b0, 2, 1'b0, '0, fr);
    chk(fr[7:0] == 8'h87, "R1 index8 last byte", 128'(fr[7:0]), 128'h87);

    // sweep reply types, indices, delays and markers
    for (int rt = 0; rt < 4; rt++) begin
      for (int j = 0; j < 4; j++) begin
        do_cmd(6'(j * 21), 32'h1357_9BDF ^ (32'(j) * 32'h0101_1111) ^ 32'(rt << 28),
               2'(rt), j[0], j[1], j * 7, 1'b0,
               {32'hC0DE_0000 + 32'(j), 32'h8421_F00D, 32'(rt) * 32'h0F0F_0F0F, 32'h7E57_A11C}, fr);
      end
    end

    // timeout boundary
    do_cmd(6'd2, 32'hA0A0_0505, 2'b11, 1'b0, 1'b0, TO - 1, 1'b0,
           128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, fr);
    do_cmd(6'd3, 32'h0000_FFFF, 2'b01, 1'b1, 1'b0, TO - 1, 1'b0, '0, fr);
    do_cmd(6'd3, 32'h0000_FFFF, 2'b01, 1'b1, 1'b0, TO, 1'b0, '0, fr);
    do_cmd(6'd9, 32'h0F00_0000, 2'b11, 1'b0, 1'b1, TO, 1'b0, '1, fr);

    // CRC corruption per type
    do_cmd(6'd13, 32'h0001_0000, 2'b01, 1'b1, 1'b0, 1, 1'b1, '0, fr);
    do_cmd(6'd52, 32'h1000_2000, 2'b10, 1'b1, 1'b0, 1, 1'b1, '0, fr);
    do_cmd(6'd10, 32'h0, 2'b11, 1'b0, 1'b0, 3, 1'b1,
           128'hFFFF_0000_AAAA_5555_1234_5678_9ABC_DEF0, fr);

    // aborts in preamble, frame and wait
    abort_at(3, 2'b00);
    abort_at(20, 2'b01);
    abort_at(62, 2'b11);
    do_cmd(6'd55, 32'h0, 2'b01, 1'b0, 1'b0, 4, 1'b0, '0, fr);

    // idle write with run bit clear does nothing
    seen = 1'b0;
    issue(13'h0112, 32'hFFFF_FFFF);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cmd_oe || busy) seen = 1'b1;
    end
    chk(!seen, "R9 idle write without run bit", 128'(seen), 128'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule